// File: doc/BRIEF.md
# Microstepping Phase Current Translator

This block turns a pulse-and-direction command stream into current setpoints for the two windings of a bipolar stepper motor. A rising edge on the step input moves a 5-bit electrical position (32 positions of 11.25 degrees per electrical turn) by one increment. The increment size comes from a 2-bit resolution select sampled in the same cycle as the edge. The direction input chooses whether the position counts up or down. For every winding the block presents an 8-bit magnitude code for a current DAC, a polarity bit for the bridge and a decay-mode request for the current regulator.

The decay request is chosen per winding on each step. If the magnitude falls, the request follows an externally digitized decay selection. If it stays level or rises, the request is slow decay. A synchronous active-high reset stands for power-up, fault and undervoltage recovery. An active-low home command returns the position to the 45-degree home state, switches the drive off and blocks steps for as long as it is held.

Top module: `msx_top`

## Requirements
- R1: The position moves only in the first cycle in which `step_in` is seen high after being low. A step input held high for several cycles moves it once. The outputs change on the clock edge that samples the rising step.
- R2: `res_sel` as sampled in the edge cycle sets the increment: 00 moves 8 positions, 01 moves 4, 10 moves 2 and 11 moves 1.
- R3: Winding 1 magnitude at position p uses offset o = p mod 16 when that is at most 8, else 16 − (p mod 16). The code at offsets 0..8 is 255, 250, 236, 212, 180, 142, 98, 50, 0. Winding 2 takes the code at offset 8 − o.
- R4: With `dir_up` high the position increases, with it low it decreases. It wraps modulo 32 in both directions, and coarse increments are added to the current position without realignment.
- R5: Winding 1 is negative (`ph1_neg`=1) for positions 9..23 and positive for 0..7 and 25..31. Winding 2 is negative for 17..31 and positive for 1..15. At a zero-magnitude position (8 and 24 for winding 1, 0 and 16 for winding 2) the previous polarity is kept.
- R6: On a step, a winding whose new code is below its previous code requests the mode given by `decay_sel`: 00 slow, 01 mixed, 10 fast, 11 treated as mixed. Otherwise it requests slow. Output decay codes are 00 slow, 01 mixed, 10 fast.
- R7: After `rst`, the position is home (4): both codes 180, both polarities positive, both decay requests mixed, and `drive_en` high.
- R8: While `home_n` is low, from the next edge on `drive_en` is low, the outputs show the home state with mixed decay, and step edges are ignored. After release, `drive_en` returns high and stepping resumes from home.
- R9: Without a step edge, every output holds its value, whatever `dir_up`, `res_sel` and `decay_sel` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up, fault, undervoltage) |
| home_n | input | 1 | Active-low home command: outputs off, position home, steps ignored |
| step_in | input | 1 | Step pulse, acted on at its rising edge |
| dir_up | input | 1 | 1 counts the position up, 0 counts down |
| res_sel | input | 2 | Resolution select: 00 full, 01 half, 10 quarter, 11 eighth |
| decay_sel | input | 2 | Digitized decay choice for falling current: 00 slow, 01 mixed, 10 fast |
| drive_en | output | 1 | Bridge drive enable |
| ph1_mag | output | 8 | Winding 1 magnitude code |
| ph1_neg | output | 1 | Winding 1 polarity, 1 = negative |
| ph1_decay | output | 2 | Winding 1 decay request |
| ph2_mag | output | 8 | Winding 2 magnitude code |
| ph2_neg | output | 1 | Winding 2 polarity, 1 = negative |
| ph2_decay | output | 2 | Winding 2 decay request |

## Verification
Every result of this block is due one clock after the cycle in which its cause is sampled. This covers the new position after a rising step, the home state after `rst` or a low `home_n`, and the restored enable after release. The driver sets inputs on the falling edge. At the next rising edge it advances a reference model and queues the expected outputs, and the monitor compares them on the following falling edge, so each item is checked exactly one register stage after its stimulus. Because an item is queued for every clock, idle cycles and steps held high for two cycles are checked for holding still just as strictly as real moves.

// File: rtl/msx_pkg.sv
package msx_pkg;

    localparam int POS_BITS = 5;
    localparam int NPOS     = 1 << POS_BITS;
    localparam int HALF     = NPOS / 2;
    localparam int QTR      = NPOS / 4;
    localparam int MAG_BITS = 8;
    localparam int OFF_BITS = POS_BITS - 1;

    typedef logic [POS_BITS-1:0] pos_t;
    typedef logic [MAG_BITS-1:0] mag_t;
    typedef logic [OFF_BITS-1:0] off_t;

    typedef enum logic [1:0] {
        DECAY_SLOW  = 2'b00,
        DECAY_MIXED = 2'b01,
        DECAY_FAST  = 2'b10
    } decay_e;

    typedef enum logic [1:0] {
        RES_FULL    = 2'b00,
        RES_HALF    = 2'b01,
        RES_QUARTER = 2'b10,
        RES_EIGHTH  = 2'b11
    } res_e;

    typedef struct packed {
        mag_t   mag;
        logic   neg;
        decay_e decay;
    } wind_t;

    // distance from the nearest peak of a cosine-shaped winding
    function automatic off_t fold(input pos_t p);
        off_t k;
        k = p[OFF_BITS-1:0];
        if (int'(k) <= QTR) return k;
        return off_t'(HALF - int'(k));
    endfunction

    // magnitude code for an offset of 0..QTR positions from the peak
    function automatic mag_t level(input off_t o);
        case (o)
            off_t'(0): return mag_t'(255);
            off_t'(1): return mag_t'(250);
            off_t'(2): return mag_t'(236);
            off_t'(3): return mag_t'(212);
            off_t'(4): return mag_t'(180);
            off_t'(5): return mag_t'(142);
            off_t'(6): return mag_t'(98);
            off_t'(7): return mag_t'(50);
            default:   return mag_t'(0);
        endcase
    endfunction

    function automatic pos_t stride(input res_e r);
        case (r)
            RES_FULL:    return pos_t'(QTR);
            RES_HALF:    return pos_t'(QTR / 2);
            RES_QUARTER: return pos_t'(QTR / 4);
            default:     return pos_t'(1);
        endcase
    endfunction

    function automatic decay_e map_sel(input logic [1:0] s);
        case (s)
            2'b00:   return DECAY_SLOW;
            2'b10:   return DECAY_FAST;
            default: return DECAY_MIXED;
        endcase
    endfunction

endpackage

// File: rtl/msx_edge.sv
module msx_edge (
    input  logic clk,
    input  logic rst,
    input  logic step_in,
    output logic rise
);
    logic step_q;

    always_ff @(posedge clk) begin
        if (rst) step_q <= 1'b0;
        else     step_q <= step_in;
    end

    assign rise = step_in & ~step_q;
endmodule

// File: rtl/msx_position.sv
module msx_position
    import msx_pkg::*;
#(
    parameter int HOME = QTR / 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic rise,
    input  logic dir_up,
    input  res_e res,
    output pos_t pos_q,
    output pos_t pos_d
);
    localparam pos_t HOME_POS = pos_t'(HOME);

    always_comb begin
        pos_d = pos_q;
        if (rst || hold)
            pos_d = HOME_POS;
        else if (rise)
            pos_d = dir_up ? pos_q + stride(res) : pos_q - stride(res);
    end

    always_ff @(posedge clk) begin
        pos_q <= pos_d;
    end
endmodule

// File: rtl/msx_winding.sv
module msx_winding
    import msx_pkg::*;
#(
    parameter int SHIFT = 0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   hold,
    input  logic   rise,
    input  pos_t   pos_next,
    input  decay_e req,
    output wind_t  w
);
    localparam pos_t SHIFT_POS = pos_t'(SHIFT);
    localparam pos_t Q1 = pos_t'(QTR);
    localparam pos_t Q3 = pos_t'(3 * QTR);

    pos_t rel;
    off_t off;
    mag_t new_mag;
    logic at_zero;
    logic neg_zone;

    always_comb begin
        rel      = pos_next - SHIFT_POS;
        off      = fold(rel);
        new_mag  = level(off);
        at_zero  = (int'(off) == QTR);
        neg_zone = (rel > Q1) && (rel < Q3);
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            w.mag   <= new_mag;
            w.neg   <= neg_zone;
            w.decay <= DECAY_MIXED;
        end else if (rise) begin
            w.mag   <= new_mag;
            w.neg   <= at_zero ? w.neg : neg_zone;
            w.decay <= (new_mag < w.mag) ? req : DECAY_SLOW;
        end
    end
endmodule

// File: rtl/msx_top.sv
module msx_top
    import msx_pkg::*;
#(
    parameter int HOME = QTR / 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       home_n,
    input  logic       step_in,
    input  logic       dir_up,
    input  logic [1:0] res_sel,
    input  logic [1:0] decay_sel,
    output logic       drive_en,
    output logic [7:0] ph1_mag,
    output logic       ph1_neg,
    output logic [1:0] ph1_decay,
    output logic [7:0] ph2_mag,
    output logic       ph2_neg,
    output logic [1:0] ph2_decay
);
    localparam int NWIND = 2;

    logic   hold;
    logic   rise;
    pos_t   pos_q;
    pos_t   pos_d;
    decay_e req;
    wind_t  wind [NWIND];

    assign hold = ~home_n;
    assign req  = map_sel(decay_sel);

    msx_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .step_in(step_in),
        .rise   (rise)
    );

    msx_position #(.HOME(HOME)) u_pos (
        .clk   (clk),
        .rst   (rst),
        .hold  (hold),
        .rise  (rise),
        .dir_up(dir_up),
        .res   (res_e'(res_sel)),
        .pos_q (pos_q),
        .pos_d (pos_d)
    );

    // winding 2 lags winding 1 by a quarter of an electrical turn
    for (genvar g = 0; g < NWIND; g++) begin : g_wind
        msx_winding #(.SHIFT(g * QTR)) u_wind (
            .clk     (clk),
            .rst     (rst),
            .hold    (hold),
            .rise    (rise),
            .pos_next(pos_d),
            .req     (req),
            .w       (wind[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)       drive_en <= 1'b1;
        else if (hold) drive_en <= 1'b0;
        else           drive_en <= 1'b1;
    end

    assign ph1_mag   = wind[0].mag;
    assign ph1_neg   = wind[0].neg;
    assign ph1_decay = wind[0].decay;
    assign ph2_mag   = wind[1].mag;
    assign ph2_neg   = wind[1].neg;
    assign ph2_decay = wind[1].decay;
endmodule

// File: rtl/msx_checker.sv
module msx_checker (
    input logic       clk,
    input logic       rst,
    input logic       home_n,
    input logic       step_in,
    input logic       drive_en,
    input logic [7:0] ph1_mag,
    input logic       ph1_neg,
    input logic [1:0] ph1_decay,
    input logic [7:0] ph2_mag,
    input logic       ph2_neg,
    input logic [1:0] ph2_decay
);
    logic step_prev;
    logic edge_c;

    always_ff @(posedge clk) begin
        if (rst) step_prev <= 1'b0;
        else     step_prev <= step_in;
    end

    assign edge_c = step_in & ~step_prev;

    assert_hold_off_R8: assert property (@(posedge clk) disable iff (rst)
        !home_n |=> !drive_en);

    assert_hold_home_R8: assert property (@(posedge clk) disable iff (rst)
        !home_n |=> (ph1_mag == 8'd180 && ph2_mag == 8'd180 &&
                     ph1_decay == 2'b01 && ph2_decay == 2'b01));

    assert_quiet_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (home_n && !edge_c) |=> ($stable(ph1_mag) && $stable(ph2_mag) &&
                                 $stable(ph1_neg) && $stable(ph2_neg) &&
                                 $stable(ph1_decay) && $stable(ph2_decay)));

    assert_held_step_R1: assert property (@(posedge clk) disable iff (rst)
        (home_n && step_in && step_prev) |=> ($stable(ph1_mag) && $stable(ph2_mag)));

    assert_slow_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
        (home_n && edge_c) |=> ((ph1_mag < $past(ph1_mag)) || ph1_decay == 2'b00));

    assert_slow_on_rise2_R6: assert property (@(posedge clk) disable iff (rst)
        (home_n && edge_c) |=> ((ph2_mag < $past(ph2_mag)) || ph2_decay == 2'b00));

    assert_zero_keeps_sign_R5: assert property (@(posedge clk) disable iff (rst)
        (ph1_mag == 8'd0) |=> (ph1_mag != 8'd0 || $stable(ph1_neg)));

    assert_complement_R3: assert property (@(posedge clk) disable iff (rst)
        (ph1_mag == 8'd255) |-> (ph2_mag == 8'd0));
endmodule

bind msx_top msx_checker u_msx_checker (
    .clk      (clk),
    .rst      (rst),
    .home_n   (home_n),
    .step_in  (step_in),
    .drive_en (drive_en),
    .ph1_mag  (ph1_mag),
    .ph1_neg  (ph1_neg),
    .ph1_decay(ph1_decay),
    .ph2_mag  (ph2_mag),
    .ph2_neg  (ph2_neg),
    .ph2_decay(ph2_decay)
);

// File: tb/test_msx_top.sv
`timescale 1ns/1ps
module test_msx_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       home_n;
    logic       step_in;
    logic       dir_up;
    logic [1:0] res_sel;
    logic [1:0] decay_sel;
    logic       drive_en;
    logic [7:0] ph1_mag, ph2_mag;
    logic       ph1_neg, ph2_neg;
    logic [1:0] ph1_decay, ph2_decay;

    always #4 clk = ~clk;

    msx_top i_msx_top (
        .clk(clk), .rst(rst), .home_n(home_n), .step_in(step_in),
        .dir_up(dir_up), .res_sel(res_sel), .decay_sel(decay_sel),
        .drive_en(drive_en),
        .ph1_mag(ph1_mag), .ph1_neg(ph1_neg), .ph1_decay(ph1_decay),
        .ph2_mag(ph2_mag), .ph2_neg(ph2_neg), .ph2_decay(ph2_decay)
    );

    typedef struct {
        string      tag;
        logic [7:0] m1, m2;
        logic       n1, n2, en;
        logic [1:0] d1, d2;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int         m_idx;
    logic       m_sp;
    logic [7:0] e_m1, e_m2;
    logic       e_n1, e_n2, e_en;
    logic [1:0] e_d1, e_d2;

    function automatic logic [7:0] code_at(int o);
        logic [7:0] tab [9] = '{8'd255, 8'd250, 8'd236, 8'd212, 8'd180,
                                8'd142, 8'd98, 8'd50, 8'd0};
        return tab[o];
    endfunction

    function automatic logic [1:0] req_of(logic [1:0] s);
        return (s == 2'b11) ? 2'b01 : s;
    endfunction

    task automatic model_home();
        m_idx = 4;
        e_m1 = 8'd180; e_m2 = 8'd180;
        e_n1 = 1'b0;   e_n2 = 1'b0;
        e_d1 = 2'b01;  e_d2 = 2'b01;
    endtask

    task automatic model_clock();
        logic edge_s;
        int   inc, k, o;
        logic [7:0] nm1, nm2;
        if (rst) begin
            m_sp = 1'b0;
            model_home();
            e_en = 1'b1;
            return;
        end
        edge_s = step_in && !m_sp;
        m_sp   = step_in;
        if (!home_n) begin
            model_home();
            e_en = 1'b0;
            return;
        end
        e_en = 1'b1;
        if (edge_s) begin
            inc = (res_sel == 2'b00) ? 8 : (res_sel == 2'b01) ? 4 :
                  (res_sel == 2'b10) ? 2 : 1;
            m_idx = dir_up ? (m_idx + inc) % 32 : (m_idx + 32 - inc) % 32;
            k = m_idx % 16;
            o = (k <= 8) ? k : 16 - k;
            nm1 = code_at(o);
            nm2 = code_at(8 - o);
            e_d1 = (nm1 < e_m1) ? req_of(decay_sel) : 2'b00;
            e_d2 = (nm2 < e_m2) ? req_of(decay_sel) : 2'b00;
            e_m1 = nm1;
            e_m2 = nm2;
            if (m_idx != 8 && m_idx != 24) e_n1 = (m_idx > 8 && m_idx < 24);
            if (m_idx != 0 && m_idx != 16) e_n2 = (m_idx > 16);
        end
    endtask

    // driver: one clock, model update and expectation push
    task automatic tick(string tag);
        exp_t e;
        @(posedge clk);
        model_clock();
        e.tag = tag; e.m1 = e_m1; e.m2 = e_m2; e.n1 = e_n1; e.n2 = e_n2;
        e.en = e_en; e.d1 = e_d1; e.d2 = e_d2;
        q.push_back(e);
        @(negedge clk);
    endtask

    // step held high two cycles, then low one cycle
    task automatic pulse(string tag);
        step_in = 1'b1; tick(tag); tick(tag);
        step_in = 1'b0; tick(tag);
    endtask

    // monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            bit bad;
            e = q.pop_front();
            checks++;
            bad = 0;
            if (ph1_mag !== e.m1 || ph2_mag !== e.m2) begin
                $display("FAIL %s magnitude: act %0d/%0d exp %0d/%0d", e.tag, ph1_mag, ph2_mag, e.m1, e.m2);
                bad = 1;
            end
            if (ph1_neg !== e.n1 || ph2_neg !== e.n2) begin
                $display("FAIL %s polarity: act %b/%b exp %b/%b", e.tag, ph1_neg, ph2_neg, e.n1, e.n2);
                bad = 1;
            end
            if (ph1_decay !== e.d1 || ph2_decay !== e.d2) begin
                $display("FAIL %s decay: act %b/%b exp %b/%b", e.tag, ph1_decay, ph2_decay, e.d1, e.d2);
                bad = 1;
            end
            if (drive_en !== e.en) begin
                $display("FAIL %s drive_en: act %b exp %b", e.tag, drive_en, e.en);
                bad = 1;
            end
            if (bad) errors++;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: act running exp finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; home_n = 1'b1; step_in = 1'b0; dir_up = 1'b1;
        res_sel = 2'b11; decay_sel = 2'b10;
        m_sp = 1'b0; e_en = 1'b1; model_home();
        @(negedge clk);
        tick("R7"); tick("R7"); tick("R7");
        rst = 1'b0;
        tick("R7"); tick("R7");

        // R6: first eighth step forward, winding 1 falls (fast), winding 2 rises (slow)
        pulse("R6");
        // R3 / R5: full electrical turn in eighth steps, decay choice rotating
        for (int i = 0; i < 32; i++) begin
            decay_sel = 2'(i % 4);
            pulse((i % 2) ? "R5" : "R3");
        end
        // R4: full steps downward, wrapping below zero
        dir_up = 1'b0; res_sel = 2'b00; decay_sel = 2'b01;
        for (int i = 0; i < 5; i++) pulse("R4");
        // R2: half and quarter increments from an unaligned position
        dir_up = 1'b1; res_sel = 2'b11; pulse("R2");
        res_sel = 2'b01;
        for (int i = 0; i < 3; i++) pulse("R2");
        res_sel = 2'b10; dir_up = 1'b0;
        for (int i = 0; i < 5; i++) pulse("R2");
        // R9: selects change with no step edge
        res_sel = 2'b00; tick("R9");
        dir_up = 1'b1; tick("R9");
        decay_sel = 2'b10; tick("R9"); tick("R9");
        // R2: the changed select applies at the following edge
        pulse("R2");
        // R1: step held high for many cycles moves once
        res_sel = 2'b11;
        step_in = 1'b1;
        for (int i = 0; i < 6; i++) tick("R1");
        step_in = 1'b0; tick("R1");
        // R8: home command, steps ignored while held
        home_n = 1'b0;
        tick("R8");
        pulse("R8"); pulse("R8");
        home_n = 1'b1;
        tick("R8");
        pulse("R8"); pulse("R8");
        // R7: reset mid-run returns home
        rst = 1'b1; tick("R7");
        rst = 1'b0; tick("R7");

        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule